// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a host in a clocked clock domain read and write an external static RAM of 512K bytes that has no clock of its own. The RAM is driven through three active-low strobes (select, write, output drive), a 19-bit address and a shared byte-wide data bus. On the die side the data bus is split into an output value, an output drive enable and an input value, and the pad ring joins them. The host offers one request at a time, made up of an address, a direction flag and a write byte. The block takes the request only while it reports ready. It then steps the strobes through a fixed phase sequence and ends every access with a single-cycle completion pulse. After a read, that pulse carries the byte that was read.

The length of each phase is a wait count worked out when the block is elaborated. The count is the nanosecond figure for that phase divided by the clock period parameter, rounded up, and never less than one cycle. Reads allow for both the address access time and the output-enable access time. Writes hold the address steady before the write strobe falls. The write strobe closes the write, and the select strobe releases one cycle later. The data bus is driven only while the write strobe is low. After every read, an idle gap gives the RAM time to release the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and in the first idle cycle after it, select, write and output strobes are high (inactive), the data drive enable is low, the completion pulse is low and ready is high.
- R2: A request is taken only on a clock edge where ready and the request valid are both high. Ready is low from the cycle after that edge until the access ends. A request held valid while busy does not change the address pins or restart the sequence. With no request, the pins stay idle.
- R3: A read holds select low, output enable low and write high for N_RD cycles, where N_RD is the larger of the wait counts for the address access time and the output-enable access time. The request address stays on the address pins.
- R4: The read byte is sampled from the bus input at the edge that ends the last output-enabled cycle. In the next cycle the completion pulse is high for exactly one cycle and the read data output holds that byte.
- R5: After each read, select and output enable stay high for N_TURN cycles, the bus-release wait count, before ready returns. No write drives the bus within N_TURN cycles of output enable rising.
- R6: A write first spends N_AS cycles (address setup count) with select low and write high. It then spends N_WP cycles with write low and the drive enable high, where N_WP is the larger of the pulse-width and data-setup counts. The drive output carries the write byte. The address does not change while write is low.
- R7: A write ends when write rises while select is still low. Select rises one cycle later. The completion pulse is high during that one cycle. Write is never low while select is high.
- R8: Output enable is high at every cycle where the drive enable is high, so the RAM and the block never drive the bus together.
- R9: Every wait count equals the smallest whole number of clock periods that covers the required nanoseconds, and is at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Block is idle and will take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte read, valid with done after a read |
| sram_addr | output | 19 | RAM address pins |
| sram_ce_n | output | 1 | RAM select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_o | output | 8 | Byte driven toward the bus |
| sram_dq_oe | output | 1 | Drive enable for the bus pads |
| sram_dq_i | input | 8 | Byte seen on the bus |

## Verification
The bench's RAM model returns the inverted byte until the output has been enabled for N_RD cycles. A design that samples the bus one cycle early therefore returns wrong data. Reads are placed directly before writes so that a missing or short bus-release gap shows up as an early drive enable or an early ready. Writes to the same address are followed by reads of it, and the lowest and highest addresses are both used. This catches a write strobe that opens before the address settles, or a write that closes on select instead of on write. Requests are held valid while the block is busy, so a block that accepts a second request early changes the address pins and breaks the expected pin pattern.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_WSETUP,
    PH_WPULSE,
    PH_WREC
  } phase_e;

  // Round required time up to whole clock periods, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned count_width(input int unsigned max_val);
    int unsigned w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int N_RD   = 4,
  parameter int N_TURN = 2,
  parameter int N_AS   = 1,
  parameter int N_WP   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_zero,
  output logic             ready,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             rd_capture,
  output logic             wr_finish,
  output phase_e           phase_d
);

  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(N_TURN - 1);
  localparam logic [CNT_W-1:0] AS_LD   = CNT_W'(N_AS - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(N_WP - 1);

  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_comb begin
    phase_d    = phase_q;
    accept     = 1'b0;
    timer_load = 1'b0;
    timer_val  = '0;
    rd_capture = 1'b0;
    wr_finish  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept     = 1'b1;
          timer_load = 1'b1;
          if (req_write) begin
            phase_d   = PH_WSETUP;
            timer_val = AS_LD;
          end else begin
            phase_d   = PH_READ;
            timer_val = RD_LD;
          end
        end
      end
      PH_READ: begin
        if (timer_zero) begin
          rd_capture = 1'b1;
          phase_d    = PH_TURN;
          timer_load = 1'b1;
          timer_val  = TURN_LD;
        end
      end
      PH_TURN: begin
        if (timer_zero) phase_d = PH_IDLE;
      end
      PH_WSETUP: begin
        if (timer_zero) begin
          phase_d    = PH_WPULSE;
          timer_load = 1'b1;
          timer_val  = WP_LD;
        end
      end
      PH_WPULSE: begin
        if (timer_zero) begin
          wr_finish = 1'b1;
          phase_d   = PH_WREC;
        end
      end
      PH_WREC: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign ready = (phase_q == PH_IDLE);

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_e        phase_d,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rd_capture,
  input  logic          wr_finish,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic          done,
  output logic [DW-1:0] rdata
);

  logic sel_d;
  assign sel_d = (phase_d == PH_READ) || (phase_d == PH_WSETUP) ||
                 (phase_d == PH_WPULSE) || (phase_d == PH_WREC);

  // Strobes come straight from flops so the RAM never sees a decode glitch.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      ce_n  <= !sel_d;
      we_n  <= (phase_d != PH_WPULSE);
      oe_n  <= (phase_d != PH_READ);
      dq_oe <= (phase_d == PH_WPULSE);
      done  <= rd_capture || wr_finish;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      dq_o  <= '0;
      rdata <= '0;
    end else begin
      if (accept) begin
        addr <= req_addr;
        dq_o <= req_wdata;
      end
      if (rd_capture) rdata <= dq_i;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW             = 19,
  parameter int DW             = 8,
  parameter int CLK_PERIOD_NS  = 20,
  parameter int T_ACCESS_NS    = 70,
  parameter int T_OE_ACCESS_NS = 35,
  parameter int T_RELEASE_NS   = 25,
  parameter int T_ADDR_SU_NS   = 5,
  parameter int T_WPULSE_NS    = 55,
  parameter int T_DSETUP_NS    = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int N_RD   = int'(max_u(ns_to_cycles(T_ACCESS_NS, CLK_PERIOD_NS),
                                     ns_to_cycles(T_OE_ACCESS_NS, CLK_PERIOD_NS)));
  localparam int N_TURN = int'(ns_to_cycles(T_RELEASE_NS, CLK_PERIOD_NS));
  localparam int N_AS   = int'(ns_to_cycles(T_ADDR_SU_NS, CLK_PERIOD_NS));
  localparam int N_WP   = int'(max_u(ns_to_cycles(T_WPULSE_NS, CLK_PERIOD_NS),
                                     ns_to_cycles(T_DSETUP_NS, CLK_PERIOD_NS)));
  localparam int N_MAX  = int'(max_u(max_u(N_RD, N_TURN), max_u(N_AS, N_WP)));
  localparam int CNT_W  = int'(count_width(N_MAX));

  // Named internal events, visible to the bound checker.
  logic             accept;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_zero;
  logic             rd_capture;
  logic             wr_finish;
  phase_e           phase_d;

  sram_ctrl_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .zero     (timer_zero)
  );

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .N_RD(N_RD), .N_TURN(N_TURN), .N_AS(N_AS), .N_WP(N_WP)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .timer_zero (timer_zero),
    .ready      (req_ready),
    .accept     (accept),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .rd_capture (rd_capture),
    .wr_finish  (wr_finish),
    .phase_d    (phase_d)
  );

  sram_ctrl_pins #(.AW(AW), .DW(DW)) i_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_d    (phase_d),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_capture (rd_capture),
    .wr_finish  (wr_finish),
    .dq_i       (sram_dq_i),
    .addr       (sram_addr),
    .ce_n       (sram_ce_n),
    .we_n       (sram_we_n),
    .oe_n       (sram_oe_n),
    .dq_o       (sram_dq_o),
    .dq_oe      (sram_dq_oe),
    .done       (done),
    .rdata      (rdata)
  );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int AW     = 19,
  parameter int N_TURN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          rd_capture,
  input logic          wr_finish,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic          sram_dq_oe
);

  // Cycles since output enable was last low, saturating.
  logic [7:0] oe_gap;
  always_ff @(posedge clk) begin
    if (!rst_n)          oe_gap <= 8'hFF;
    else if (!sram_oe_n) oe_gap <= 8'h00;
    else if (oe_gap != 8'hFF) oe_gap <= oe_gap + 8'h01;
  end

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_ce_n && sram_we_n));

  p_capture_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_capture || wr_finish) |=> done);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (int'(oe_gap) >= N_TURN));

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> $stable(sram_addr));

  p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe == !sram_we_n);

  p_we_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

  p_ce_after_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_ce_n) |-> $past(sram_we_n));

  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

endmodule

bind sram_async_ctrl sram_ctrl_checker #(.AW(AW), .N_TURN(N_TURN)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .rd_capture (rd_capture),
  .wr_finish  (wr_finish),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done;
  logic [7:0]  rdata;
  logic [18:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i = 8'h00;

  always #(PERIOD/2) clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  int vectors = 0;
  int fails   = 0;
  bit finished = 0;

  // Wait count written as a search: smallest c >= 1 with c*PERIOD >= ns (R9).
  function automatic int cyc(input int ns);
    int c = 1;
    while (c * PERIOD < ns) c++;
    return c;
  endfunction

  int n_rd, n_turn, n_as, n_wp;

  typedef struct {
    bit          ce, we, oe, dqoe, dn, isrd;
    logic [18:0] a;
    logic [7:0]  d;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [7:0] mem [int];

  function automatic logic [7:0] mem_val(input logic [18:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[18:11];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // Reference model and RAM model, evaluated between edges.
  int   rd_age  = 0;
  bit   prev_rd = 0;
  bit   prev_we = 1;
  logic [18:0] wr_a = '0;
  logic [7:0]  wr_d = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      bit idle;
      bit reading;
      idle = (q.size() == 0);
      if (idle) e = '{ce:1, we:1, oe:1, dqoe:0, dn:0, isrd:0, a:'0, d:'0, tag:"R2"};
      else      e = q.pop_front();
      chk(req_ready == idle, e.tag, "ready", int'(req_ready), int'(idle));
      chk(sram_ce_n == e.ce, e.tag, "ce_n", int'(sram_ce_n), int'(e.ce));
      chk(sram_we_n == e.we, e.tag, "we_n", int'(sram_we_n), int'(e.we));
      chk(sram_oe_n == e.oe, e.tag, "oe_n", int'(sram_oe_n), int'(e.oe));
      chk(sram_dq_oe == e.dqoe, e.tag, "dq_oe", int'(sram_dq_oe), int'(e.dqoe));
      chk(done == e.dn, "R4", "done", int'(done), int'(e.dn));
      if (!idle) chk(sram_addr == e.a, e.tag, "addr", int'(sram_addr), int'(e.a));
      if (e.dqoe) chk(sram_dq_o == e.d, e.tag, "dq_o", int'(sram_dq_o), int'(e.d));
      if (e.dn && e.isrd) chk(rdata == e.d, "R4", "rdata", int'(rdata), int'(e.d));
      chk(!(sram_dq_oe && !sram_oe_n), "R8", "contention", 1, 0);

      // RAM: data valid only after n_rd cycles of output enable.
      reading = !sram_ce_n && !sram_oe_n && sram_we_n;
      rd_age  = reading ? (prev_rd ? rd_age + 1 : 0) : 0;
      prev_rd = reading;
      if (reading) sram_dq_i = (rd_age >= n_rd - 1) ? mem_val(sram_addr) : ~mem_val(sram_addr);
      else         sram_dq_i = 8'h00;
      if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
        wr_a = sram_addr;
        wr_d = sram_dq_o;
      end
      if (!prev_we && sram_we_n && !sram_ce_n) mem[int'(wr_a)] = wr_d;
      prev_we = sram_we_n;

      // Acceptance at the coming edge.
      if (idle && req_valid) begin
        if (!req_write) begin
          for (int i = 0; i < n_rd; i++)
            q.push_back('{ce:0, we:1, oe:0, dqoe:0, dn:0, isrd:1, a:req_addr, d:'0, tag:"R3 R9"});
          for (int i = 0; i < n_turn; i++)
            q.push_back('{ce:1, we:1, oe:1, dqoe:0, dn:(i == 0), isrd:1, a:req_addr,
                          d:mem_val(req_addr), tag:"R5"});
        end else begin
          for (int i = 0; i < n_as; i++)
            q.push_back('{ce:0, we:1, oe:1, dqoe:0, dn:0, isrd:0, a:req_addr, d:req_wdata, tag:"R6 R9"});
          for (int i = 0; i < n_wp; i++)
            q.push_back('{ce:0, we:0, oe:1, dqoe:1, dn:0, isrd:0, a:req_addr, d:req_wdata, tag:"R6 R9"});
          q.push_back('{ce:0, we:1, oe:1, dqoe:0, dn:1, isrd:0, a:req_addr, d:req_wdata, tag:"R7"});
        end
      end
    end
  end

  task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    n_rd   = (cyc(70) > cyc(35)) ? cyc(70) : cyc(35);
    n_turn = cyc(25);
    n_as   = cyc(5);
    n_wp   = (cyc(55) > cyc(30)) ? cyc(55) : cyc(30);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sram_ce_n && sram_we_n && sram_oe_n, "R1", "strobes", int'({sram_ce_n, sram_we_n, sram_oe_n}), 7);
    chk(!sram_dq_oe && !done, "R1", "dq_oe/done", int'({sram_dq_oe, done}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);          // R2 idle with no request
    #1;
    issue(0, 19'h00123, 8'h00);         // read of untouched location
    issue(1, 19'h00123, 8'h5A);         // read then write: turnaround R5
    issue(0, 19'h00123, 8'h00);         // write then read same address
    issue(1, 19'h00000, 8'hC3);         // lowest address
    issue(1, 19'h7FFFF, 8'h3C);         // back-to-back writes, highest address
    issue(0, 19'h00000, 8'h00);
    issue(0, 19'h7FFFF, 8'h00);         // back-to-back reads
    for (int k = 0; k < 6; k++)
      issue(k[0], 19'(19'h2A000 + k * 19'h111), 8'(8'h10 + k * 7));
    issue(0, 19'h2A111, 8'h00);
    issue(0, 19'h2A333, 8'h00);
    issue(0, 19'h2A555, 8'h00);
    repeat (4) @(posedge clk);
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
    summary();
  end

endmodule